// File: doc/BRIEF.md
# Oscillator Band Search Sequencer

This block chooses one of eight overlapping oscillator bands without software help. A search starts when reset is released and again every time the feedback-divider register is written. While a search runs, the block holds a tuning-hold output high. That output tells the analog side to cut the tuning node off from the loop filter and tie it to a fixed internal voltage. The search finds the three-bit band code one bit at a time, from the most significant bit down. Each trial bit is kept or cleared according to a frequency-comparison input. A settling step and a latch step follow. When the search ends, the tuning hold is released and normal loop action resumes.

The timing clock of the search is the reference-counter output pulse, passed through a prescaler. A two-bit select field sets the prescaler to divide by 1, 2, 4 or 8. A search always takes the same number of divided ticks. The last band code found is held steady between searches.

Top module: `vco_band_sequencer`

## Requirements
- R1: While reset is asserted and on its release, busy and tuneHold are 1 and bandCode is 0. A search begins by itself when reset ends, with no write needed.
- R2: A search ends on exactly its fifth divided tick. busy is still 1 just before the reference pulse that forms that tick, and it is 0 in the cycle after that pulse.
- R3: tuneHold is 1 for the whole of every search and 0 once the search has ended.
- R4: A divided tick is formed by every (1 << divSel)-th refTick pulse counted from the start of the search: divSel 0 gives 1 pulse, 1 gives 2, 2 gives 4 and 3 gives 8.
- R5: The band code is found by successive approximation. On divided ticks 1, 2 and 3, cmpUp decides bits 2, 1 and 0 of the code in turn (1 keeps the bit, 0 clears it). The code latched at the end is {d2,d1,d0}, where dN is the value of cmpUp on the tick that decides bit N.
- R6: cmpUp has no effect at any other time: on refTick pulses that do not form a divided tick, and on the settling tick (4) and the latch tick (5).
- R7: A pulse on nWrite during a search restarts it from tick 1. It also clears the prescaler, so that five full divided ticks are again needed.
- R8: While the block is idle, bandCode and busy do not change, whatever refTick and cmpUp do.
- R9: A pulse on nWrite while the block is idle sets busy in the next cycle. bandCode keeps its previous value until the new search latches its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle pulse from the reference counter |
| divSel | input | 2 | Prescaler select: divide by 1 << divSel |
| nWrite | input | 1 | One-cycle strobe on a write to the feedback-divider register |
| cmpUp | input | 1 | Comparison result: 1 keeps the trial bit |
| tuneHold | output | 1 | Tuning node held at internal reference |
| busy | output | 1 | Search in progress |
| bandCode | output | 3 | Selected oscillator band |

## Verification
The bench builds the block with its defaults: three code bits, five divided ticks per search and a two-bit prescaler select. These values keep every prescaler ratio, up to divide by 8, short enough to run as a whole search. The vector walk covers all four ratios and several decision patterns. On every pulse that does not decide a bit, the bench drives the opposite comparison value. Directed tests restart a search after an odd number of reference pulses, so that any prescaler count left over from the old search would shift the end of the new one. They also hammer the idle block with pulses.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  // Strobes from the control to the band datapath
  typedef struct packed {
    logic restart;  // load the first trial code
    logic decide;   // resolve the bit under test with the comparator
    logic commit;   // copy the trial code to the output
  } bselStrobe_t;
endpackage

// File: rtl/bsel_prescale.sv
module bsel_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             refTick,
  input  logic [SEL_W-1:0] divSel,
  output logic             divTick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limit;

  assign limit   = PRE_W'((1 << divSel) - 1);
  assign divTick = refTick && !clear && (preCnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (clear)   preCnt <= '0;
    else if (divTick) preCnt <= '0;
    else if (refTick) preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/bsel_ctrl.sv
module bsel_ctrl
  import bsel_pkg::*;
#(
  parameter int STEPS     = 5,
  parameter int BAND_BITS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        nWrite,
  input  logic        divTick,
  output logic        busy,
  output bselStrobe_t strobe
);
  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] stepCnt;
  logic              advance;
  logic              lastStep;

  assign advance  = divTick && busy && !nWrite;
  assign lastStep = (stepCnt == STEP_W'(STEPS - 1));

  assign strobe.restart = nWrite;
  assign strobe.decide  = advance && (stepCnt < STEP_W'(BAND_BITS));
  assign strobe.commit  = advance && lastStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b1;
      stepCnt <= '0;
    end else if (nWrite) begin
      busy    <= 1'b1;
      stepCnt <= '0;
    end else if (advance) begin
      if (lastStep) begin
        busy    <= 1'b0;
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  AST_RESTART_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    nWrite |=> (busy && stepCnt == '0));                         // R7
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(divTick));                             // R2
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !nWrite) |=> !busy);                               // R8
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt < STEP_W'(STEPS));                                   // R2
endmodule

// File: rtl/bsel_band_dp.sv
module bsel_band_dp
  import bsel_pkg::*;
#(
  parameter int BAND_BITS  = 3,
  parameter int RESET_BAND = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bselStrobe_t          strobe,
  input  logic                 cmpUp,
  output logic [BAND_BITS-1:0] bandCode
);
  localparam logic [BAND_BITS-1:0] TOP_BIT = {1'b1, {(BAND_BITS-1){1'b0}}};

  logic [BAND_BITS-1:0] trial;
  logic [BAND_BITS-1:0] probe;  // one-hot bit under test

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial    <= TOP_BIT;
      probe    <= TOP_BIT;
      bandCode <= BAND_BITS'(RESET_BAND);
    end else begin
      if (strobe.restart) begin
        trial <= TOP_BIT;
        probe <= TOP_BIT;
      end else if (strobe.decide) begin
        trial <= (trial & ~probe) | (cmpUp ? probe : '0) | (probe >> 1);
        probe <= probe >> 1;
      end
      if (strobe.commit) bandCode <= trial;
    end
  end

  AST_PROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(probe));                                            // R5
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(bandCode));                       // R8
  AST_RESTART_TRIAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (trial == TOP_BIT && probe == TOP_BIT));  // R5
endmodule

// File: rtl/vco_band_sequencer.sv
module vco_band_sequencer
  import bsel_pkg::*;
#(
  parameter int BAND_BITS  = 3,
  parameter int STEPS      = 5,
  parameter int SEL_W      = 2,
  parameter int RESET_BAND = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refTick,
  input  logic [SEL_W-1:0]     divSel,
  input  logic                 nWrite,
  input  logic                 cmpUp,
  output logic                 tuneHold,
  output logic                 busy,
  output logic [BAND_BITS-1:0] bandCode
);
  logic        divTick;
  logic        busyInt;
  bselStrobe_t strobe;

  bsel_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rstN(rstN), .clear(nWrite), .refTick(refTick),
    .divSel(divSel), .divTick(divTick)
  );

  bsel_ctrl #(.STEPS(STEPS), .BAND_BITS(BAND_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .nWrite(nWrite), .divTick(divTick),
    .busy(busyInt), .strobe(strobe)
  );

  bsel_band_dp #(.BAND_BITS(BAND_BITS), .RESET_BAND(RESET_BAND)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpUp(cmpUp),
    .bandCode(bandCode)
  );

  assign busy     = busyInt;
  assign tuneHold = busyInt;
endmodule

// File: tb/sim_vco_band_sequencer.sv
module sim_vco_band_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic       nWrite = 1'b0;
  logic       cmpUp = 1'b0;
  logic       tuneHold;
  logic       busy;
  logic [2:0] bandCode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  vco_band_sequencer u0 (
    .clk(clk), .rstN(rstN), .refTick(refTick), .divSel(divSel),
    .nWrite(nWrite), .cmpUp(cmpUp), .tuneHold(tuneHold), .busy(busy),
    .bandCode(bandCode)
  );

  // {divSel, d2, d1, d0}
  localparam logic [4:0] VEC [6] = '{5'b00_101, 5'b01_011, 5'b10_110,
                                     5'b11_000, 5'b00_111, 5'b01_100};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic refPulse();
    @(negedge clk) refTick = 1'b1;
    @(negedge clk) refTick = 1'b0;
  endtask

  task automatic writePulse();
    @(negedge clk) nWrite = 1'b1;
    @(negedge clk) nWrite = 1'b0;
  endtask

  // Drive one whole search; opposite comparator values on non-deciding pulses (R6)
  task automatic runSel(input logic [1:0] div, input logic [2:0] d, input logic [2:0] prev);
    int r = 1 << div;
    int n = 0;
    divSel = div;
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < r; j++) begin
        n++;
        if (j == r - 1 && k < 3) cmpUp = d[2-k];
        else cmpUp = (k < 3) ? ~d[2-k] : ~d[k-3];
        if (n == 5 * r) begin
          chk(busy == 1'b1, "R2 busy before last tick", busy, 1);
          chk(tuneHold == 1'b1, "R3 hold during search", tuneHold, 1);
          chk(bandCode == prev, "R9 old code kept", bandCode, prev);
        end
        refPulse();
      end
    end
    chk(busy == 1'b0, "R2/R4 busy after fifth tick", busy, 0);
    chk(tuneHold == 1'b0, "R3 hold released", tuneHold, 0);
    chk(bandCode == d, "R5/R6 band code", bandCode, d);
  endtask

  initial begin
    logic [2:0] last;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    chk(tuneHold == 1'b1, "R1 hold in reset", tuneHold, 1);
    chk(bandCode == 3'd0, "R1 code in reset", bandCode, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    runSel(2'd0, 3'b101, 3'd0);  // R1 power-up search
    last = 3'b101;

    // Vector walk, R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      writePulse();
      chk(busy == 1'b1, "R9 busy after write", busy, 1);
      runSel(VEC[v][4:3], VEC[v][2:0], last);
      last = VEC[v][2:0];
    end

    // R7: restart mid-search after an odd pulse count
    divSel = 2'd1;
    writePulse();
    cmpUp = 1'b1;
    repeat (3) refPulse();
    writePulse();
    chk(busy == 1'b1, "R7 busy after restart", busy, 1);
    runSel(2'd1, 3'b010, last);
    last = 3'b010;

    // R7 at ratio 4 with a restart late in the search
    divSel = 2'd2;
    writePulse();
    cmpUp = 1'b0;
    repeat (13) refPulse();
    writePulse();
    runSel(2'd2, 3'b111, last);
    last = 3'b111;

    // R8: idle block ignores pulses and comparator
    for (int i = 0; i < 16; i++) begin
      cmpUp = i[0];
      divSel = i[1:0];
      refPulse();
      if (i % 4 == 3) begin
        chk(busy == 1'b0, "R8 idle busy", busy, 0);
        chk(bandCode == last, "R8 idle code", bandCode, last);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule